// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block chooses which physical frame to give up when a new page must be brought in. It keeps one reference bit per frame and a circular hand pointer. Every access strobe sets the bit of the frame it names. When an eviction is requested, a scan starts at the current hand. At each frame it visits, a set bit is cleared and the hand moves on. The first frame found with a clear bit becomes the victim.

The hand stays where the last scan left it, which is the frame just after the last victim. The next scan therefore carries on around the circle. A frame that has been referenced since the hand last passed it is spared once, so the block approximates least-recently-used replacement with a single bit per frame. When every bit is set, the choice reduces to first-in first-out order. The scan does nothing between requests. One request is served at a time, and the block signals that it is busy while a scan is in progress.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset `scan_busy` and `victim_valid` are low, all reference bits are clear and the hand is at frame 0, so the first eviction returns frame 0 after one examination.
- R2: An access strobe (`acc_valid` high with `acc_frame` < NUM_FRAMES) sets the reference bit of that frame at the next clock edge.
- R3: Accesses while no scan is running never produce `victim_valid` and never raise `scan_busy`.
- R4: A scan examines one frame per clock. A frame whose bit is clear is returned on `victim_idx` with a one-cycle `victim_valid` pulse. The pulse is seen k cycles after the accepting edge, where k is the number of frames examined.
- R5: A frame examined with its bit set is not chosen, and its bit is cleared.
- R6: The hand moves in circular order, wrapping from frame NUM_FRAMES-1 to frame 0.
- R7: If all bits are set when a scan starts, the scan clears them all, returns to its starting frame and evicts it after NUM_FRAMES+1 examinations.
- R8: After a victim v is returned, the next scan starts at frame (v+1) mod NUM_FRAMES.
- R9: An access to the frame under the hand in the same cycle it is examined takes priority. That frame is not chosen, and its bit is left set.
- R10: `scan_busy` is high from the edge that accepts `evict_req` until the edge that returns the victim. A request made while busy is ignored and produces no second victim.
- R11: `victim_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe for a frame |
| acc_frame | input | IDX_W | Frame index of the access |
| evict_req | input | 1 | Request for a victim; accepted when `scan_busy` is low |
| scan_busy | output | 1 | A scan is in progress; requests are held off |
| victim_valid | output | 1 | One-cycle acknowledge carrying the chosen frame |
| victim_idx | output | IDX_W | Index of the chosen frame, valid with `victim_valid` |

## Verification
The access path and the scan can both act on the same reference bit in one cycle: the scan wants to clear it or take the frame, while the access wants to set it. The bench provokes this by driving an access to the frame under the hand in the very cycle after the request is accepted, which is the cycle of the first examination. The judgment is that the scan skips that frame and takes the next one, two examinations in. A later full revolution of the hand then skips that frame again, which shows that its bit stayed set. A second overlap, a new request arriving while a scan is busy, is judged by counting acknowledges: exactly one must appear.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          clr_en,
   input  logic [IW-1:0] clr_idx,
   output logic [N-1:0]  bits
);

   // One flop per frame; a set request outranks a clear on the same frame.
   for (genvar g = 0; g < N; g++) begin : g_bit
      logic hit_set;
      logic hit_clr;
      assign hit_set = set_en && (set_idx == IW'(g));
      assign hit_clr = clr_en && (clr_idx == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       bits[g] <= 1'b0;
         else if (hit_set) bits[g] <= 1'b1;
         else if (hit_clr) bits[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/hand_ptr.sv
module hand_ptr #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [IW-1:0] ptr
);
   import clksel_pkg::*;

   logic [IW-1:0] ptr_nx;

   if (is_pow2(N)) begin : g_wrap_free
      // Natural overflow of the index field closes the circle.
      assign ptr_nx = ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nx = (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= ptr_nx;
   end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
   parameter int unsigned IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evict_req,
   input  logic          hit_here,
   input  logic [IW-1:0] hand,
   output logic          busy,
   output logic          adv,
   output logic          clr_here,
   output logic          victim_valid,
   output logic [IW-1:0] victim_idx
);
   import clksel_pkg::*;

   scan_state_e state_q, state_d;

   assign busy     = (state_q == SCAN_RUN);
   assign adv      = busy;
   assign clr_here = busy && hit_here;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SCAN_IDLE: if (evict_req) state_d = SCAN_RUN;
         SCAN_RUN:  if (!hit_here) state_d = SCAN_IDLE;
         default:   state_d = SCAN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SCAN_IDLE;
         victim_valid <= 1'b0;
         victim_idx   <= '0;
      end else begin
         state_q      <= state_d;
         victim_valid <= busy && !hit_here;
         if (busy && !hit_here) victim_idx <= hand;
      end
   end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
   parameter int unsigned NUM_FRAMES = 8,
   localparam int unsigned IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [IDX_W-1:0] acc_frame,
   input  logic             evict_req,
   output logic             scan_busy,
   output logic             victim_valid,
   output logic [IDX_W-1:0] victim_idx
);

   if (NUM_FRAMES < 2) begin : g_bad_cfg
      $error("clock_victim_sel: NUM_FRAMES must be at least 2");
   end

   logic [NUM_FRAMES-1:0] ref_q;
   logic [IDX_W-1:0]      hand_q;
   logic                  adv;
   logic                  clr_here;
   logic                  acc_at_hand;
   logic                  hit_here;

   // An access landing on the examined frame counts as a reference this cycle.
   assign acc_at_hand = acc_valid && (acc_frame == hand_q);
   assign hit_here    = ref_q[hand_q] || acc_at_hand;

   ref_bit_array #(.N(NUM_FRAMES), .IW(IDX_W)) u_refs (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (acc_valid),
      .set_idx (acc_frame),
      .clr_en  (clr_here),
      .clr_idx (hand_q),
      .bits    (ref_q)
   );

   hand_ptr #(.N(NUM_FRAMES), .IW(IDX_W)) u_hand (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .ptr   (hand_q)
   );

   scan_ctrl #(.IW(IDX_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .evict_req    (evict_req),
      .hit_here     (hit_here),
      .hand         (hand_q),
      .busy         (scan_busy),
      .adv          (adv),
      .clr_here     (clr_here),
      .victim_valid (victim_valid),
      .victim_idx   (victim_idx)
   );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          acc_valid,
   input logic [IW-1:0] acc_frame,
   input logic          evict_req,
   input logic          scan_busy,
   input logic          victim_valid,
   input logic [IW-1:0] victim_idx,
   input logic [IW-1:0] hand_q,
   input logic [N-1:0]  ref_q
);

   logic [IW-1:0] after_victim;
   assign after_victim = (victim_idx == IW'(N - 1)) ? '0 : victim_idx + 1'b1;

   logic acc_ok;
   assign acc_ok = acc_valid && (int'(acc_frame) < N);

   // R2: an access sets the bit of its frame
   p_access_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> ref_q[$past(acc_frame)]);

   // R3: a victim only follows a running scan
   p_no_idle_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> $past(scan_busy));

   // R4: the end of a scan is marked by the acknowledge
   p_end_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_busy) |-> victim_valid);

   // R8: the hand rests just past the victim
   p_hand_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> (hand_q == after_victim));

   // R9: a concurrent access on the examined frame keeps it
   p_keep_touched_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && acc_valid && (acc_frame == hand_q))
      |=> (!victim_valid && ref_q[$past(hand_q)]));

   // R10: an idle request is accepted at once
   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_busy && evict_req) |=> scan_busy);

   // R11: the acknowledge lasts one cycle
   p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |=> !victim_valid);

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.N(NUM_FRAMES), .IW(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_frame    (acc_frame),
   .evict_req    (evict_req),
   .scan_busy    (scan_busy),
   .victim_valid (victim_valid),
   .victim_idx   (victim_idx),
   .hand_q       (hand_q),
   .ref_q        (ref_q)
);

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;

   localparam int NF = 6;
   localparam int IW = $clog2(NF);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [IW-1:0] acc_frame = '0;
   logic          evict_req = 1'b0;
   logic          scan_busy;
   logic          victim_valid;
   logic [IW-1:0] victim_idx;

   int vectors = 0;
   int misses  = 0;

   // bench model of the reference bits and hand
   bit m_ref [NF];
   int m_hand = 0;

   always #2 clk = ~clk;

   clock_victim_sel #(.NUM_FRAMES(NF)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_valid    (acc_valid),
      .acc_frame    (acc_frame),
      .evict_req    (evict_req),
      .scan_busy    (scan_busy),
      .victim_valid (victim_valid),
      .victim_idx   (victim_idx)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
   endtask

   task automatic touch(input int f);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_frame = IW'(f);
      @(negedge clk);
      acc_valid = 1'b0;
      m_ref[f] = 1'b1;
   endtask

   // One eviction. acc_f >= 0 drives an access during the first examination;
   // nag drives a second request while the scan is busy.
   task automatic evict(input string req, input int acc_f, input bit nag);
      int exp_v, exp_k, p, k;
      bit got;
      if (acc_f >= 0) m_ref[acc_f] = 1'b1;
      p = m_hand; exp_k = 0;
      forever begin
         exp_k++;
         if (m_ref[p]) begin
            if (!(exp_k == 1 && acc_f == p)) m_ref[p] = 1'b0;
            p = (p + 1) % NF;
         end else begin
            exp_v = p;
            m_hand = (p + 1) % NF;
            break;
         end
      end
      @(negedge clk);
      evict_req = 1'b1;
      @(negedge clk);
      evict_req = nag;
      check("R10", "busy after accept", int'(scan_busy), 1);
      if (acc_f >= 0) begin
         acc_valid = 1'b1;
         acc_frame = IW'(acc_f);
      end
      k = 0; got = 1'b0;
      while (k < 4 * NF && !got) begin
         @(negedge clk);
         acc_valid = 1'b0;
         evict_req = 1'b0;
         k++;
         if (victim_valid) got = 1'b1;
      end
      check("R4", "victim seen", int'(got), 1);
      check(req, "victim index", int'(victim_idx), exp_v);
      check(req, "examinations", k, exp_k);
      check("R10", "busy low at victim", int'(scan_busy), 0);
      @(negedge clk);
      check("R11", "pulse one cycle", int'(victim_valid), 0);
      if (nag) begin
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10", "request while busy ignored", int'(victim_valid | scan_busy), 0);
         end
      end
   endtask

   task automatic t_reset();
      check("R1", "busy after reset", int'(scan_busy), 0);
      check("R1", "valid after reset", int'(victim_valid), 0);
      evict("R1", -1, 1'b0);                 // frame 0 in one step
   endtask

   task automatic t_idle_access();
      touch(1);
      touch(2);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R3", "idle accesses give no victim", int'(victim_valid | scan_busy), 0);
      end
      evict("R5", -1, 1'b0);                 // R2: skips 1,2 and takes 3
   endtask

   task automatic t_wrap();
      evict("R8", -1, 1'b0);                 // 4
      evict("R8", -1, 1'b0);                 // 5
      evict("R6", -1, 1'b0);                 // wraps to 0
   endtask

   task automatic t_all_set();
      for (int f = 0; f < NF; f++) touch(f);
      evict("R7", -1, 1'b1);                 // start frame after NF+1 steps; R10 nag
   endtask

   task automatic t_concurrent();
      evict("R9", m_hand, 1'b0);             // hand frame kept, next one taken
      for (int i = 0; i < NF; i++) evict("R9", -1, 1'b0);  // later lap skips it
   endtask

   initial begin
      for (int i = 0; i < NF; i++) m_ref[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_access();
      t_wrap();
      t_all_set();
      t_concurrent();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      misses++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

endmodule